// File: doc/BRIEF.md
# Warp Divergence and Reconvergence Controller

This block keeps the program counter and the active-lane mask for one warp of parallel lanes that all execute the same instruction. Each cycle it may receive one of two events. The first is a branch, which carries a per-lane taken predicate, a target address, a fall-through address and a join address. The second is a plain advance, which carries the next sequential address. When every active lane agrees on a branch, the warp moves to the chosen side and its mask does not change. When the lanes disagree, the block saves a reconvergence record and runs the taken lanes first. The remaining lanes run next. At the join address it restores the mask that was active before the branch.

The block is a small state machine with three states. In RUN it accepts events. In RECONV it resolves one stack level per cycle and ignores its inputs. In HALT the stack has overflowed and the warp is frozen until reset. The transitions are as follows:
- RUN to RECONV when the next address equals the join address on top of the stack.
- RUN to HALT when a divergent branch arrives while the stack is full.
- RECONV to RUN once the resolved address is not yet the next join.
- RECONV stays in RECONV while successive levels share one join address, or while the else side is empty.

Each stack record holds the join address, the address and mask of the pending side, the full pre-branch mask and a flag that marks the pending side as done.

Top module: `warp_reconv_ctrl`

## Requirements
- R1: After reset `cur_pc` is RESET_PC (0), `cur_mask` has all 32 bits set, `ready` is 1 and `ovf_err` is 0.
- R2: In RUN, an advance with no branch loads `adv_pc` into `cur_pc` on the next edge and leaves `cur_mask` unchanged.
- R3: In RUN, a branch where every active lane is taken loads `br_target` into `cur_pc`, keeps `cur_mask`, and pushes no record, so that a later arrival at its join address does not drop `ready`.
- R4: In RUN, a branch where no active lane is taken (taken bits on inactive lanes do not count) loads `br_fall` into `cur_pc` and keeps `cur_mask`. The side with no lanes never issues.
- R5: A divergent branch (some, but not all, active lanes taken) sets `cur_mask` to `br_taken & cur_mask` and `cur_pc` to `br_target` on the next edge. The mask is never all zero.
- R6: When the taken side reaches its join address, the next edge shows `cur_pc` = join with `ready` = 0. The edge after that shows `cur_pc` = fall-through, with the mask set to the active lanes that were not taken, and `ready` = 1.
- R7: When the not-taken side reaches the join address, the next edge shows `cur_pc` = join with `ready` = 0. The edge after that restores the full pre-branch mask at the join address with `ready` = 1.
- R8: Divergence nests up to DEPTH (8) levels. Inner reconvergence restores the enclosing side's mask. Levels that share a join address unwind one per cycle, with `ready` = 0 until the last one.
- R9: A side whose first address equals the join address is skipped. For an empty taken side, the edge after the branch shows `ready` = 0 and the edge after that starts the other side.
- R10: A divergent branch that arrives with DEPTH records stored sets `ovf_err` and clears `ready`. It leaves `cur_pc` and `cur_mask` unchanged, and they stay frozen until reset.
- R11: While `ready` is 0, both branch and advance inputs are ignored.
- R12: When a branch and an advance arrive in the same cycle, the branch wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | A branch event is present this cycle |
| br_taken | input | LANES | Per-lane taken predicate |
| br_target | input | PCW | Address of the taken side |
| br_fall | input | PCW | Address of the not-taken side |
| br_join | input | PCW | Address where both sides reunite |
| adv_valid | input | 1 | A sequential advance is present this cycle |
| adv_pc | input | PCW | Next sequential address |
| cur_pc | output | PCW | Address the warp issues from |
| cur_mask | output | LANES | Lanes enabled for the current instruction |
| ready | output | 1 | High in RUN; events are only accepted then |
| ovf_err | output | 1 | Stack overflow; the warp is halted |

## Verification
The properties assume that a branch's join address is reached by both of its sides. They also assume that the address stream is well nested, so that an inner join is reached before an outer one. The stimulus follows these rules by driving advances that land exactly on each join in order. It only presents new events while `ready` is high, except where inputs are driven on purpose during RECONV or HALT to show that they are ignored.

// File: rtl/wrc_pkg.sv
package wrc_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_RECONV = 2'd1,
        ST_HALT   = 2'd2
    } wrc_state_e;

    typedef enum logic [1:0] {
        BK_TAKEN = 2'd0,
        BK_FALL  = 2'd1,
        BK_SPLIT = 2'd2
    } wrc_kind_e;

endpackage

// File: rtl/wrc_branch_eval.sv
module wrc_branch_eval
    import wrc_pkg::*;
#(
    parameter int LANES = 32
) (
    input  logic [LANES-1:0] taken,
    input  logic [LANES-1:0] active,
    output wrc_kind_e        kind,
    output logic [LANES-1:0] taken_lanes,
    output logic [LANES-1:0] other_lanes
);

    always_comb begin
        taken_lanes = taken & active;
        other_lanes = active & ~taken;
        if (taken_lanes == active) begin
            kind = BK_TAKEN;
        end else if (taken_lanes == '0) begin
            kind = BK_FALL;
        end else begin
            kind = BK_SPLIT;
        end
    end

endmodule

// File: rtl/wrc_stack.sv
module wrc_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 97,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    input  logic          wr_top,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  top_data,
    output logic [W-1:0]  below_data,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    logic [W-1:0]  mem [DEPTH];
    logic [CW-1:0] count_q;
    logic [CW-1:0] top_c;
    logic [CW-1:0] below_c;
    logic [IW-1:0] push_idx;
    logic [IW-1:0] top_idx;
    logic [IW-1:0] below_idx;

    always_comb begin
        top_c     = count_q - CW'(1);
        below_c   = count_q - CW'(2);
        push_idx  = count_q[IW-1:0];
        top_idx   = top_c[IW-1:0];
        below_idx = below_c[IW-1:0];
    end

    assign count      = count_q;
    assign full       = (count_q == CW'(DEPTH));
    assign empty      = (count_q == '0);
    assign top_data   = (count_q > CW'(0)) ? mem[top_idx] : '0;
    assign below_data = (count_q > CW'(1)) ? mem[below_idx] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (push && !full) begin
            count_q <= count_q + CW'(1);
        end else if (pop && !empty) begin
            count_q <= count_q - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full) begin
            mem[push_idx] <= push_data;
        end else if (wr_top && !empty) begin
            mem[top_idx] <= wr_data;
        end
    end

endmodule

// File: rtl/warp_reconv_ctrl.sv
module warp_reconv_ctrl
    import wrc_pkg::*;
#(
    parameter int           LANES    = 32,
    parameter int           PCW      = 16,
    parameter int           DEPTH    = 8,
    parameter logic [15:0]  RESET_PC = 16'h0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             br_valid,
    input  logic [LANES-1:0] br_taken,
    input  logic [PCW-1:0]   br_target,
    input  logic [PCW-1:0]   br_fall,
    input  logic [PCW-1:0]   br_join,
    input  logic             adv_valid,
    input  logic [PCW-1:0]   adv_pc,
    output logic [PCW-1:0]   cur_pc,
    output logic [LANES-1:0] cur_mask,
    output logic             ready,
    output logic             ovf_err
);

    typedef struct packed {
        logic [PCW-1:0]   join_pc;
        logic [PCW-1:0]   pend_pc;
        logic [LANES-1:0] pend_mask;
        logic [LANES-1:0] full_mask;
        logic             else_done;
    } ent_t;

    localparam int ENT_W = $bits(ent_t);
    localparam int CW    = $clog2(DEPTH + 1);

    wrc_state_e       state_q, state_d;
    logic [PCW-1:0]   pc_q, pc_d;
    logic [LANES-1:0] mask_q, mask_d;

    wrc_kind_e        br_kind;
    logic [LANES-1:0] tk_lanes;
    logic [LANES-1:0] nt_lanes;

    logic             stk_push, stk_pop, stk_wr;
    ent_t             push_ent, wr_ent, top_ent, below_ent;
    logic [ENT_W-1:0] top_raw, below_raw;
    logic [CW-1:0]    stk_count;
    logic             stk_full, stk_empty;

    wrc_branch_eval #(.LANES(LANES)) eval_i (
        .taken       (br_taken),
        .active      (mask_q),
        .kind        (br_kind),
        .taken_lanes (tk_lanes),
        .other_lanes (nt_lanes)
    );

    wrc_stack #(.DEPTH(DEPTH), .W(ENT_W)) stack_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (stk_push),
        .push_data  (push_ent),
        .pop        (stk_pop),
        .wr_top     (stk_wr),
        .wr_data    (wr_ent),
        .top_data   (top_raw),
        .below_data (below_raw),
        .count      (stk_count),
        .full       (stk_full),
        .empty      (stk_empty)
    );

    assign top_ent   = ent_t'(top_raw);
    assign below_ent = ent_t'(below_raw);

    // next-state and datapath decisions
    always_comb begin
        state_d  = state_q;
        pc_d     = pc_q;
        mask_d   = mask_q;
        stk_push = 1'b0;
        stk_pop  = 1'b0;
        stk_wr   = 1'b0;
        push_ent = '0;
        wr_ent   = top_ent;
        unique case (state_q)
            ST_RUN: begin
                if (br_valid) begin
                    unique case (br_kind)
                        BK_TAKEN: begin
                            pc_d = br_target;
                            if (!stk_empty && br_target == top_ent.join_pc) begin
                                state_d = ST_RECONV;
                            end
                        end
                        BK_FALL: begin
                            pc_d = br_fall;
                            if (!stk_empty && br_fall == top_ent.join_pc) begin
                                state_d = ST_RECONV;
                            end
                        end
                        default: begin
                            if (stk_full) begin
                                state_d = ST_HALT;
                            end else begin
                                stk_push           = 1'b1;
                                push_ent.join_pc   = br_join;
                                push_ent.pend_pc   = br_fall;
                                push_ent.pend_mask = nt_lanes;
                                push_ent.full_mask = mask_q;
                                push_ent.else_done = 1'b0;
                                pc_d               = br_target;
                                mask_d             = tk_lanes;
                                if (br_target == br_join) begin
                                    state_d = ST_RECONV;
                                end
                            end
                        end
                    endcase
                end else if (adv_valid) begin
                    pc_d = adv_pc;
                    if (!stk_empty && adv_pc == top_ent.join_pc) begin
                        state_d = ST_RECONV;
                    end
                end
            end
            ST_RECONV: begin
                if (!top_ent.else_done) begin
                    stk_wr           = 1'b1;
                    wr_ent.else_done = 1'b1;
                    pc_d             = top_ent.pend_pc;
                    mask_d           = top_ent.pend_mask;
                    state_d = (top_ent.pend_pc == top_ent.join_pc) ? ST_RECONV : ST_RUN;
                end else begin
                    stk_pop = 1'b1;
                    pc_d    = top_ent.join_pc;
                    mask_d  = top_ent.full_mask;
                    if (stk_count > CW'(1) && below_ent.join_pc == top_ent.join_pc) begin
                        state_d = ST_RECONV;
                    end else begin
                        state_d = ST_RUN;
                    end
                end
            end
            ST_HALT: begin
                state_d = ST_HALT;
            end
            default: begin
                state_d = ST_RUN;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            pc_q    <= PCW'(RESET_PC);
            mask_q  <= '1;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            mask_q  <= mask_d;
        end
    end

    // outputs
    always_comb begin
        cur_pc   = pc_q;
        cur_mask = mask_q;
        ready    = (state_q == ST_RUN);
        ovf_err  = (state_q == ST_HALT);
    end

endmodule

// File: rtl/warp_reconv_ctrl_chk.sv
module warp_reconv_ctrl_chk #(
    parameter int LANES = 32,
    parameter int PCW   = 16,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             br_valid,
    input logic [LANES-1:0] br_taken,
    input logic [PCW-1:0]   br_target,
    input logic [PCW-1:0]   br_fall,
    input logic             adv_valid,
    input logic [PCW-1:0]   adv_pc,
    input logic [PCW-1:0]   cur_pc,
    input logic [LANES-1:0] cur_mask,
    input logic             ready,
    input logic             ovf_err,
    input logic [CW-1:0]    depth,
    input logic             stk_full
);

    logic all_tk, none_tk, split;
    assign all_tk  = ((br_taken & cur_mask) == cur_mask);
    assign none_tk = ((br_taken & cur_mask) == '0);
    assign split   = !all_tk && !none_tk;

    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        ready && !br_valid && adv_valid |=> (cur_pc == $past(adv_pc)) && (cur_mask == $past(cur_mask)));

    a_r3_uniform_taken: assert property (@(posedge clk) disable iff (!rst_n)
        ready && br_valid && all_tk |=> (cur_pc == $past(br_target)) && (cur_mask == $past(cur_mask)));

    a_r4_uniform_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ready && br_valid && none_tk |=> (cur_pc == $past(br_fall)) && (cur_mask == $past(cur_mask)));

    a_r5_split_mask: assert property (@(posedge clk) disable iff (!rst_n)
        ready && br_valid && split && !stk_full |=> cur_mask == $past(br_taken & cur_mask));

    a_r5_mask_live: assert property (@(posedge clk) disable iff (!rst_n)
        cur_mask != '0);

    a_r8_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= CW'(DEPTH));

    a_r10_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ready && br_valid && split && stk_full |=> ovf_err && !ready);

    a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err && $stable(cur_pc) && $stable(cur_mask));

endmodule

bind warp_reconv_ctrl warp_reconv_ctrl_chk #(
    .LANES (LANES),
    .PCW   (PCW),
    .DEPTH (DEPTH)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .br_valid  (br_valid),
    .br_taken  (br_taken),
    .br_target (br_target),
    .br_fall   (br_fall),
    .adv_valid (adv_valid),
    .adv_pc    (adv_pc),
    .cur_pc    (cur_pc),
    .cur_mask  (cur_mask),
    .ready     (ready),
    .ovf_err   (ovf_err),
    .depth     (stk_count),
    .stk_full  (stk_full)
);

// File: tb/warp_reconv_ctrl_tb_top.sv
`timescale 1ns/1ps
module warp_reconv_ctrl_tb_top;

    localparam int LANES = 32;
    localparam int PCW   = 16;
    localparam int DEPTH = 8;

    typedef struct packed {
        logic        bv;
        logic [31:0] tk;
        logic [15:0] tgt;
        logic [15:0] fal;
        logic [15:0] jn;
        logic        av;
        logic [15:0] apc;
        logic [15:0] epc;
        logic [31:0] emask;
        logic        erdy;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 25;
    // R2 R3 R4 R5 R6 R7 R8 R9 R11 R12 exercised by the rows below
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h0,        16'h0,   16'h0,   16'h0,   1'b1, 16'h0004, 16'h0004, 32'hFFFFFFFF, 1'b1, 4'd2},  // R2
        '{1'b1, 32'hFFFFFFFF, 16'h0040, 16'h0008, 16'h0080, 1'b0, 16'h0,  16'h0040, 32'hFFFFFFFF, 1'b1, 4'd3},  // R3
        '{1'b0, 32'h0,        16'h0,   16'h0,   16'h0,   1'b1, 16'h0080, 16'h0080, 32'hFFFFFFFF, 1'b1, 4'd3},  // R3 no record
        '{1'b1, 32'h0,        16'h0100, 16'h0084, 16'h0090, 1'b0, 16'h0,  16'h0084, 32'hFFFFFFFF, 1'b1, 4'd4},  // R4
        '{1'b1, 32'h0000FFFF, 16'h0100, 16'h0200, 16'h0300, 1'b0, 16'h0,  16'h0100, 32'h0000FFFF, 1'b1, 4'd5},  // R5
        '{1'b0, 32'h0,        16'h0,   16'h0,   16'h0,   1'b1, 16'h0104, 16'h0104, 32'h0000FFFF, 1'b1, 4'd2},  // R2
        '{1'b1, 32'h000000FF, 16'h0110, 16'h0120, 16'h0130, 1'b0, 16'h0,  16'h0110, 32'h000000FF, 1'b1, 4'd8},  // R8
        '{1'b0, 32'h0,        16'h0,   16'h0,   16'h0,   1'b1, 16'h0130, 16'h0130, 32'h000000FF, 1'b0, 4'd6},  // R6
        '{1'b0, 32'h0,        16'h0,   16'h0,   16'h0,   1'b1, 16'h0777, 16'h0120, 32'h0000FF00, 1'b1, 4'd11}, // R11
        '{1'b0, 32'h0,        16'h0,   16'h0,   16'h0,   1'b1, 16'h0130, 16'h0130, 32'h0000FF00, 1'b0, 4'd7},  // R7
        '{1'b0, 32'h0,        16'h0,   16'h0,   16'h0,   1'b0, 16'h0,    16'h0130, 32'h0000FFFF, 1'b1, 4'd7},  // R7
        '{1'b0, 32'h0,        16'h0,   16'h0,   16'h0,   1'b1, 16'h0300, 16'h0300, 32'h0000FFFF, 1'b0, 4'd6},  // R6
        '{1'b0, 32'h0,        16'h0,   16'h0,   16'h0,   1'b0, 16'h0,    16'h0200, 32'hFFFF0000, 1'b1, 4'd6},  // R6
        '{1'b1, 32'h0000FFFF, 16'h0500, 16'h0204, 16'h0999, 1'b0, 16'h0,  16'h0204, 32'hFFFF0000, 1'b1, 4'd4},  // R4 inactive bits
        '{1'b0, 32'h0,        16'h0,   16'h0,   16'h0,   1'b1, 16'h0300, 16'h0300, 32'hFFFF0000, 1'b0, 4'd7},  // R7
        '{1'b0, 32'h0,        16'h0,   16'h0,   16'h0,   1'b0, 16'h0,    16'h0300, 32'hFFFFFFFF, 1'b1, 4'd7},  // R7
        '{1'b1, 32'h00000001, 16'h0400, 16'h0410, 16'h0400, 1'b0, 16'h0,  16'h0400, 32'h00000001, 1'b0, 4'd9},  // R9
        '{1'b0, 32'h0,        16'h0,   16'h0,   16'h0,   1'b0, 16'h0,    16'h0410, 32'hFFFFFFFE, 1'b1, 4'd9},  // R9
        '{1'b1, 32'hFFFFFFFE, 16'h0420, 16'h0428, 16'h0400, 1'b1, 16'h0999, 16'h0420, 32'hFFFFFFFE, 1'b1, 4'd12}, // R12
        '{1'b1, 32'h00000002, 16'h0430, 16'h0438, 16'h0400, 1'b0, 16'h0,  16'h0430, 32'h00000002, 1'b1, 4'd8},  // R8
        '{1'b0, 32'h0,        16'h0,   16'h0,   16'h0,   1'b1, 16'h0400, 16'h0400, 32'h00000002, 1'b0, 4'd6},  // R6
        '{1'b0, 32'h0,        16'h0,   16'h0,   16'h0,   1'b0, 16'h0,    16'h0438, 32'hFFFFFFFC, 1'b1, 4'd6},  // R6
        '{1'b0, 32'h0,        16'h0,   16'h0,   16'h0,   1'b1, 16'h0400, 16'h0400, 32'hFFFFFFFC, 1'b0, 4'd7},  // R7
        '{1'b1, 32'h0000000F, 16'h0777, 16'h0778, 16'h0779, 1'b0, 16'h0,  16'h0400, 32'hFFFFFFFE, 1'b0, 4'd8},  // R8 chain, R11 ignored
        '{1'b0, 32'h0,        16'h0,   16'h0,   16'h0,   1'b0, 16'h0,    16'h0400, 32'hFFFFFFFF, 1'b1, 4'd8}   // R8
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             br_valid = 1'b0;
    logic [LANES-1:0] br_taken = '0;
    logic [PCW-1:0]   br_target = '0;
    logic [PCW-1:0]   br_fall = '0;
    logic [PCW-1:0]   br_join = '0;
    logic             adv_valid = 1'b0;
    logic [PCW-1:0]   adv_pc = '0;
    logic [PCW-1:0]   cur_pc;
    logic [LANES-1:0] cur_mask;
    logic             ready;
    logic             ovf_err;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    warp_reconv_ctrl #(.LANES(LANES), .PCW(PCW), .DEPTH(DEPTH)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .br_valid  (br_valid),
        .br_taken  (br_taken),
        .br_target (br_target),
        .br_fall   (br_fall),
        .br_join   (br_join),
        .adv_valid (adv_valid),
        .adv_pc    (adv_pc),
        .cur_pc    (cur_pc),
        .cur_mask  (cur_mask),
        .ready     (ready),
        .ovf_err   (ovf_err)
    );

    task automatic check(input string req, input logic [15:0] epc, input logic [31:0] emask,
                         input logic erdy, input logic eovf);
        checks++;
        if (cur_pc !== epc || cur_mask !== emask || ready !== erdy || ovf_err !== eovf) begin
            errors++;
            $display("FAIL %s: pc=%h mask=%h ready=%b ovf=%b expected pc=%h mask=%h ready=%b ovf=%b",
                     req, cur_pc, cur_mask, ready, ovf_err, epc, emask, erdy, eovf);
        end
    endtask

    task automatic step(input logic bv, input logic [31:0] tk, input logic [15:0] tgt,
                        input logic [15:0] fal, input logic [15:0] jn,
                        input logic av, input logic [15:0] apc);
        br_valid  = bv;
        br_taken  = tk;
        br_target = tgt;
        br_fall   = fal;
        br_join   = jn;
        adv_valid = av;
        adv_pc    = apc;
        @(posedge clk);
        @(negedge clk);
        br_valid  = 1'b0;
        adv_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 16'h0000, 32'hFFFFFFFF, 1'b1, 1'b0);

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].bv, VECS[i].tk, VECS[i].tgt, VECS[i].fal, VECS[i].jn,
                 VECS[i].av, VECS[i].apc);
            check($sformatf("R%0d row %0d", VECS[i].req, i), VECS[i].epc, VECS[i].emask,
                  VECS[i].erdy, 1'b0);
        end

        // R8: fill all DEPTH levels, then R10: one more split overflows
        m = 32'hFFFFFFFF;
        for (int i = 0; i < DEPTH; i++) begin
            m = m & (m - 32'd1);
            step(1'b1, m, 16'h2000 + 16'(i * 16), 16'h4000 + 16'(i), 16'h5000 + 16'(i), 1'b0, 16'h0);
            check("R8 nest", 16'h2000 + 16'(i * 16), m, 1'b1, 1'b0);
        end
        step(1'b1, m & (m - 32'd1), 16'h3000, 16'h3100, 16'h3200, 1'b0, 16'h0);
        check("R10 overflow", 16'h2070, 32'hFFFFFF00, 1'b0, 1'b1);
        step(1'b0, 32'h0, 16'h0, 16'h0, 16'h0, 1'b1, 16'h0ABC);
        check("R10 frozen R11", 16'h2070, 32'hFFFFFF00, 1'b0, 1'b1);
        step(1'b1, 32'h1, 16'h0DEF, 16'h0DE0, 16'h0DD0, 1'b0, 16'h0);
        check("R10 frozen", 16'h2070, 32'hFFFFFF00, 1'b0, 1'b1);

        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after halt", 16'h0000, 32'hFFFFFFFF, 1'b1, 1'b0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule